// File: doc/BRIEF.md
# Time-Slotted Shared RAM Streamer

This block lets two users share one single-port byte RAM. The first user is a bit-serial output path. It streams stored bytes at a fixed bit clock while an output window is open. The second user is a host port that writes new bytes into the same RAM. The block runs entirely on the bit clock. Every group of eight clocks holds one slot that only the output path may use. The seven other slots in the group go to whatever host writes are waiting.

Host writes first enter a small FIFO. Because of this, the host never has to line up with the slot grid. A pending write simply takes the next cycle that is not a read slot. When the window is closed no reads happen, so every cycle can serve a write. This makes the idle lines of a frame the natural time to refresh large areas of memory.

When the window opens, a read address counter is loaded with a start address and then advances by one byte per slot. The RAM has one cycle of read latency. Each returned byte goes into the shift register on the last bit of the byte before it, so the serial stream has no gaps between bytes.

Top module: `slot_ram_streamer`

## Requirements
- R1: While reset is held, and in the first cycle after it, serOut and ramWrEn are low and wrReady is high.
- R2: The read slot comes in the first cycle after the clock edge that samples lineActive high while the window is closed. ramAddr in that slot equals startAddr. Later read slots follow every 8 cycles while the window stays open, and each one uses the previous read address plus one.
- R3: In a read slot, ramWrEn is low and ramAddr carries the read address. A write never takes a read slot.
- R4: The byte returned by read k is shifted out least-significant bit first. Bit b appears on serOut in cycle 8k+2+b, counted from the first read slot of the window, so consecutive bytes leave no idle cycle between them.
- R5: serOut is low while the window is closed. It is also low in the two cycles between opening and the first bit.
- R6: The write FIFO holds 8 entries. wrReady is high exactly when fewer than 8 accepted writes are waiting. A write is accepted on a clock edge where wrValid and wrReady are both high.
- R7: Accepted writes reach the RAM (ramWrEn high, with ramAddr and ramWrData) in the order they were accepted, with unchanged address and data.
- R8: In every cycle that is not a read slot and has at least one write waiting, a write is issued. Outside the window this means every cycle.
- R9: The clock edge that samples lineActive low ends the window at once, even in the middle of a byte. No further read slots occur. A later opening starts again at startAddr with a fresh slot grid.
- R10: The read address wraps from the highest RAM address to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all timing counts in these cycles |
| rst | input | 1 | Synchronous reset, active high |
| lineActive | input | 1 | Output window enable, sampled on each clock edge |
| startAddr | input | ADDR_W | Read address loaded when the window opens |
| wrValid | input | 1 | Host write request |
| wrReady | output | 1 | FIFO can accept a write |
| wrAddr | input | ADDR_W | Host write address |
| wrData | input | DATA_W | Host write byte |
| ramAddr | output | ADDR_W | RAM address (read or write) |
| ramWrEn | output | 1 | RAM write enable |
| ramWrData | output | DATA_W | RAM write data |
| ramRdData | input | DATA_W | RAM read data, one cycle after the address |
| serOut | output | 1 | Serial output stream |

## Verification
The RAM is first loaded while the window is closed. The stream is then played with no host traffic, which isolates slot timing, bit order and the seam between bytes. A second window starts near the top of the address range while random host writes run in parallel. This separates a correct read priority, and reads that see freshly written bytes, from slot theft and wrong wrap-around. A continuous write burst during an open window fills the FIFO, because draining at seven slots in eight falls behind one write per cycle; this exposes wrong ready and ordering behaviour. Windows of one and three cycles, and a window that closes in the middle of a byte, test opening, early closing and restarting.

// File: rtl/srs_pkg.sv
`timescale 1ns/1ps
package srs_pkg;

  // Strobes the slot controller hands to the datapath each cycle.
  typedef struct packed {
    logic openWin;    // window opens at the coming edge
    logic readSlot;   // this cycle is the reserved read slot
    logic loadShift;  // shift register takes the RAM byte at the coming edge
    logic shiftOn;    // shift register advances at the coming edge
    logic wrGrant;    // a queued write owns the RAM this cycle
    logic streaming;  // serial output carries valid bits
  } slotStrobes_t;

endpackage

// File: rtl/srs_fifo.sv
`timescale 1ns/1ps
module srs_fifo #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushValid,
  output logic              pushReady,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic              headValid,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned ENT_W = ADDR_W + DATA_W;

  logic [ENT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             push, popOk;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign pushReady = (count != CNT_W'(DEPTH));
  assign push      = pushValid & pushReady;
  assign headValid = (count != '0);
  assign popOk     = pop & headValid;
  assign {headAddr, headData} = store[rdPtr];

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= {pushAddr, pushData};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push)  wrPtr <= nextPtr(wrPtr);
      if (popOk) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(popOk);
    end
  end

  // R6: occupancy never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R7: occupancy follows accepted pushes and issued pops
  a_r7_count_track: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count == CNT_W'($past(count) + CNT_W'($past(push)) - CNT_W'($past(popOk))));

endmodule

// File: rtl/srs_ctrl.sv
`timescale 1ns/1ps
module srs_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lineActive,
  input  logic                 fifoNotEmpty,
  output srs_pkg::slotStrobes_t strobe
);
  localparam int unsigned PH_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0] RD_PH = PH_W'(DATA_W - 2);
  localparam logic [PH_W-1:0] LD_PH = PH_W'(DATA_W - 1);

  logic            activeQ, streamQ;
  logic [PH_W-1:0] phase;

  always_comb begin
    strobe.openWin   = lineActive & ~activeQ;
    strobe.readSlot  = activeQ & (phase == RD_PH);
    strobe.loadShift = activeQ & (phase == LD_PH);
    strobe.shiftOn   = streamQ;
    strobe.wrGrant   = fifoNotEmpty & ~strobe.readSlot;
    strobe.streaming = streamQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ <= 1'b0;
      streamQ <= 1'b0;
      phase   <= '0;
    end else begin
      activeQ <= lineActive;
      if (strobe.openWin)  phase <= RD_PH;
      else if (activeQ)    phase <= (phase == LD_PH) ? '0 : phase + PH_W'(1);
      streamQ <= activeQ & lineActive & (streamQ | (phase == LD_PH));
    end
  end

  // R4: a shift load always follows a read slot by one cycle
  a_r4_load_after_read: assert property (@(posedge clk) disable iff (rst)
    strobe.loadShift |-> $past(strobe.readSlot));

  // R2: the first cycle of an opened window is a read slot
  a_r2_first_slot: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe.openWin)) |-> strobe.readSlot);

endmodule

// File: rtl/srs_datapath.sv
`timescale 1ns/1ps
module srs_datapath #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  srs_pkg::slotStrobes_t strobe,
  input  logic [ADDR_W-1:0]     startAddr,
  input  logic [ADDR_W-1:0]     headAddr,
  input  logic [DATA_W-1:0]     headData,
  input  logic [DATA_W-1:0]     ramRdData,
  output logic [ADDR_W-1:0]     ramAddr,
  output logic                  ramWrEn,
  output logic [DATA_W-1:0]     ramWrData,
  output logic                  popFifo,
  output logic                  serOut
);
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdAddr <= '0;
    end else if (strobe.openWin) begin
      rdAddr <= startAddr;
    end else if (strobe.readSlot) begin
      rdAddr <= rdAddr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobe.loadShift) begin
      shiftReg <= ramRdData;
    end else if (strobe.shiftOn) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  // Address path: the write owner selects the FIFO head, otherwise the read counter.
  assign ramAddr   = strobe.wrGrant ? headAddr : rdAddr;
  assign ramWrEn   = strobe.wrGrant;
  assign ramWrData = headData;
  assign popFifo   = strobe.wrGrant;
  assign serOut    = strobe.streaming & shiftReg[0];

  // R2 / R10: each read slot steps the read address by one, wrapping
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe.readSlot)) |-> rdAddr == ADDR_W'($past(rdAddr) + ADDR_W'(1)));

endmodule

// File: rtl/slot_ram_streamer.sv
`timescale 1ns/1ps
module slot_ram_streamer #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineActive,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWrEn,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              serOut
);
  srs_pkg::slotStrobes_t strobe;
  logic                  headValid, popFifo;
  logic [ADDR_W-1:0]     headAddr;
  logic [DATA_W-1:0]     headData;

  srs_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst),
    .pushValid(wrValid), .pushReady(wrReady),
    .pushAddr(wrAddr), .pushData(wrData),
    .pop(popFifo), .headValid(headValid),
    .headAddr(headAddr), .headData(headData)
  );

  srs_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .lineActive(lineActive), .fifoNotEmpty(headValid),
    .strobe(strobe)
  );

  srs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .startAddr(startAddr), .headAddr(headAddr), .headData(headData),
    .ramRdData(ramRdData),
    .ramAddr(ramAddr), .ramWrEn(ramWrEn), .ramWrData(ramWrData),
    .popFifo(popFifo), .serOut(serOut)
  );

  // R5: a closed window keeps the serial line low
  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !$past(lineActive) |-> !serOut);

  // R3: the read slot is never used by a write
  a_r3_slot_free: assert property (@(posedge clk) disable iff (rst)
    strobe.readSlot |-> !ramWrEn);

endmodule

// File: tb/slot_ram_streamer_tb.sv
`timescale 1ns/1ps
module slot_ram_streamer_tb_top;
  localparam int CLK_NS = 8;
  localparam int DEPTH  = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       lineActive;
  logic [7:0] startAddr;
  logic       wrValid;
  logic       wrReady;
  logic [7:0] wrAddr;
  logic [7:0] wrData;
  logic [7:0] ramAddr;
  logic       ramWrEn;
  logic [7:0] ramWrData;
  logic [7:0] ramRdData;
  logic       serOut;

  always #(CLK_NS/2) clk = ~clk;

  slot_ram_streamer dut_i (
    .clk(clk), .rst(rst), .lineActive(lineActive), .startAddr(startAddr),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .ramAddr(ramAddr), .ramWrEn(ramWrEn), .ramWrData(ramWrData),
    .ramRdData(ramRdData), .serOut(serOut)
  );

  // Synchronous RAM model, one cycle read latency
  logic [7:0] mem [256];
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    ramRdData = 8'h00;
  end
  always @(posedge clk) begin
    if (ramWrEn) mem[ramAddr] <= ramWrData;
    ramRdData <= mem[ramAddr];
  end

  int nChecks = 0;
  int nFails  = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench state
  logic [15:0] wq[$];
  bit          rstDone = 0;
  bit          winOn = 0;
  int          tCnt = 0;
  logic [7:0]  expAddr = 0;
  logic [7:0]  expBytes [256];
  bit          sawFull = 0;
  bit          pendValid = 0;

  // Monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rstDone) begin
      bit slotNow;
      bit expBit;
      slotNow = winOn && (tCnt % 8 == 0);
      // R6: ready reflects the bench's count of waiting writes
      check(wrReady == (wq.size() < DEPTH), "R6 wrReady", wrReady, wq.size() < DEPTH);
      if (!wrReady) sawFull = 1;
      // R8: a waiting write uses every non-slot cycle
      check(ramWrEn == (wq.size() > 0 && !slotNow), "R8 write issue", ramWrEn, wq.size() > 0 && !slotNow);
      if (slotNow) begin
        check(!ramWrEn, "R3 slot kept free", ramWrEn, 0);
        check(ramAddr == expAddr, "R2 read address", ramAddr, expAddr);
        if (expAddr == 8'd0 && tCnt > 0) check(ramAddr == 8'd0, "R10 wrap", ramAddr, 0);
        expBytes[(tCnt / 8) % 256] = mem[expAddr];
        expAddr = expAddr + 8'd1;
      end
      if (ramWrEn) begin
        if (wq.size() == 0) begin
          check(0, "R7 unexpected write", ramAddr, -1);
        end else begin
          logic [15:0] h;
          h = wq.pop_front();
          check({ramAddr, ramWrData} == h, "R7 write order", {ramAddr, ramWrData}, h);
        end
      end
      // R4 / R5 serial stream
      if (winOn && tCnt >= 2) expBit = expBytes[((tCnt - 2) / 8) % 256][(tCnt - 2) % 8];
      else expBit = 0;
      check(serOut == expBit, winOn ? "R4 serial bit" : "R5 idle low", serOut, expBit);
      // Window tracking for the coming edge (R9)
      if (!winOn && lineActive) begin
        winOn = 1; tCnt = 0; expAddr = startAddr;
      end else if (winOn && !lineActive) begin
        winOn = 0;
      end else if (winOn) begin
        tCnt++;
      end
    end
  end

  // One bench cycle: drive at posedge+2, sample ready at negedge
  task automatic stepCycle(input logic la, input bit want, input logic [7:0] a, input logic [7:0] d);
    bit acc;
    lineActive = la;
    if (!pendValid && want) begin
      pendValid = 1; wrAddr = a; wrData = d;
    end
    wrValid = pendValid;
    @(negedge clk);
    acc = pendValid && wrReady;
    @(posedge clk);
    if (acc) begin
      wq.push_back({wrAddr, wrData});
      pendValid = 0;
    end
    #2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int seedV;
    seedV = $urandom(32'd4711);
    rst = 1; lineActive = 0; startAddr = 0; wrValid = 0; wrAddr = 0; wrData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(serOut == 0, "R1 serOut in reset", serOut, 0);
    check(ramWrEn == 0, "R1 ramWrEn in reset", ramWrEn, 0);
    check(wrReady == 1, "R1 wrReady in reset", wrReady, 1);
    @(posedge clk); #2;
    rst = 0;
    rstDone = 1;

    // Preload all addresses with the window closed (R8: every cycle free)
    begin
      int i = 0;
      while (i < 256) begin
        stepCycle(0, 1, i[7:0], 8'($urandom));
        if (!pendValid) i++;
      end
    end
    repeat (4) stepCycle(0, 0, 0, 0);

    // Window 1: plain playback, no host traffic (R2, R4)
    startAddr = 8'd10;
    repeat (240) stepCycle(1, 0, 0, 0);
    repeat (5) stepCycle(0, 0, 0, 0);

    // Window 2: wrap near the top with random writes alongside (R3, R7, R10)
    startAddr = 8'd250;
    repeat (203) stepCycle(1, ($urandom % 10) < 6, 8'($urandom), 8'($urandom));
    repeat (20) stepCycle(0, 0, 0, 0);

    // Window 3: continuous burst fills the FIFO (R6)
    startAddr = 8'd5;
    repeat (150) stepCycle(1, 1, 8'($urandom), 8'($urandom));
    repeat (30) stepCycle(1, 0, 0, 0);
    stepCycle(0, 0, 0, 0);
    check(sawFull, "R6 FIFO became full under burst", sawFull, 1);

    // Short windows and immediate reopen (R9)
    startAddr = 8'd77;
    stepCycle(1, 0, 0, 0);
    stepCycle(0, 0, 0, 0);
    startAddr = 8'd200;
    repeat (3) stepCycle(1, 0, 0, 0);
    stepCycle(0, 0, 0, 0);
    startAddr = 8'd33;
    repeat (21) stepCycle(1, 1, 8'd34, 8'hA5);
    repeat (10) stepCycle(0, 0, 0, 0);

    // Drain and idle (R5, R8)
    while (pendValid || wq.size() > 0) stepCycle(0, 0, 0, 0);
    repeat (10) stepCycle(0, 0, 0, 0);
    check(wq.size() == 0, "R7 all writes delivered", wq.size(), 0);

    summary();
    $finish;
  end

endmodule